// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block is the digital back end of a 12-bit sampling converter. A host drives an active-low select line and a data clock. The block turns the converted value into one serial frame on a data line that it can release, and it signals when the analog section may power down. The converted value arrives as a parallel word, and the block captures it at the moment the frame starts. The analog front end, the comparator and the reference are not part of the block.

A frame starts when select falls. The data line stays released while the input is sampled, which covers the first two falling clock edges. It then drives a single low lead-in bit. The twelve result bits follow, most significant first. The same word is then replayed least significant first, starting from bit 1 because bit 0 was the last bit sent. After that the line is released again and stays inert until select is raised and lowered once more. Raising select at any point ends the frame.

Select and the data clock are taken as signals synchronous to the block clock `clk`. The block finds their edges by comparing each sample with the one before it. The result word is plain 12-bit two's complement and passes through without change. Outputs change only in the `clk` cycle after a detected falling data-clock edge, so a host can sample them on the rising data-clock edge.

Top module: `adc_serial_seq`

## Requirements
- R1: While reset is asserted, `sdo_en` is 0 and `pwr_dn` is 1.
- R2: When `cs_n` goes from 1 to 0, the block captures `result` and starts a frame in the next cycle, with `sdo_en`=0 and `pwr_dn`=0. Changes on `result` after that point do not affect the frame.
- R3: Through the first falling `dclk` edge of a frame, `sdo_en` stays 0.
- R4: After the second falling `dclk` edge, `sdo_en` is 1 and `sdo` is 0 for one data-clock period.
- R5: Falling edges 3 to 14 present the captured bits 11 down to 0 on `sdo`. Falling edge k shows bit 14-k.
- R6: Falling edges 15 to 25 present the captured bits 1 up to 11 on `sdo`. Falling edge k shows bit k-14. Bit 0 is not sent a second time.
- R7: From falling edge 26 onward, `sdo_en` is 0 and `pwr_dn` is 1. Further clocks and `result` changes have no effect while `cs_n` stays 0.
- R8: When `cs_n` is 1 at a clock edge, the next cycle has `sdo_en`=0 and `pwr_dn`=1, whatever the frame position. Falling `dclk` edges while `cs_n` is 1 have no effect.
- R9: `pwr_dn` is 0 from the frame start through the edge that presents bit 0. It is 1 from falling edge 15 onward and whenever `cs_n` is high.
- R10: While `cs_n` stays low, `sdo` and `sdo_en` change only in the cycle after a detected falling `dclk` edge.
- R11: The word is sent unchanged as 12-bit two's complement. Positive full scale 0x7FF, negative full scale 0x800, minus one 0xFFF and zero 0x000 all come out exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; select and data clock are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low select; a falling edge starts a frame, high aborts |
| dclk | input | 1 | Host data clock; its falling edges step the frame |
| result | input | 12 | Converted two's complement value, captured at frame start |
| sdo | output | 1 | Serial data bit, valid while sdo_en is 1 |
| sdo_en | output | 1 | Drive enable for the data line; 0 means high impedance |
| pwr_dn | output | 1 | Power-down indication for the analog section |

## Verification
Random words in full frames with random data-clock duty and period distinguish the two bit orders and the skipped repeat of bit 0. The skipped bit shows up as a one-position offset in the LSB-first half. Frames aborted at a random edge, including inside the sample window and inside the replay, separate an abort from a normal finish. Frames run past edge 26 show that the finished state ignores clocks. The extreme two's complement codes, together with a result word inverted right after select falls, separate capture at frame start from passing the input straight through.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Frame phases of the serial output sequencer.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // select high or no frame started
    ST_SAMPLE = 3'd1,  // sampling window, line released
    ST_NULL   = 3'd2,  // single low lead-in bit
    ST_MSB    = 3'd3,  // word, most significant bit first
    ST_LSB    = 3'd4,  // replay, bit 1 upward
    ST_DONE   = 3'd5   // frame finished, inert until select cycles
  } seq_state_e;

endpackage

// File: rtl/adc_seq_rst_sync.sv
module adc_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/adc_seq_edges.sv
module adc_seq_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic dclk,
  output logic cs_fall,
  output logic dclk_fall
);

  logic cs_q;
  logic dclk_q;

  // Previous samples reset low so a select held low through reset
  // never looks like a falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      dclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      dclk_q <= dclk;
    end
  end

  assign cs_fall   = cs_q & ~cs_n;
  assign dclk_fall = dclk_q & ~dclk;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter  int W  = 12,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cs_fall,
  input  logic          dclk_fall,
  output seq_state_e    state,
  output logic [IW-1:0] idx,
  output logic          load
);

  localparam logic [IW-1:0] IDX_TOP = IW'(W - 1);
  localparam logic [IW-1:0] IDX_ONE = IW'(1);

  seq_state_e    state_d;
  logic [IW-1:0] idx_d;
  logic          half_q;
  logic          half_d;
  logic          upd_en;

  // Registers move only on a select event or a data-clock fall.
  assign upd_en = cs_n | cs_fall | dclk_fall;

  always_comb begin
    state_d = state;
    idx_d   = idx;
    half_d  = half_q;
    load    = 1'b0;
    if (cs_n) begin
      state_d = ST_IDLE;
      half_d  = 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cs_fall) begin
            state_d = ST_SAMPLE;
            half_d  = 1'b0;
            load    = 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (dclk_fall) begin
            if (half_q) begin
              state_d = ST_NULL;
            end else begin
              half_d = 1'b1;
            end
          end
        end
        ST_NULL: begin
          if (dclk_fall) begin
            state_d = ST_MSB;
            idx_d   = IDX_TOP;
          end
        end
        ST_MSB: begin
          if (dclk_fall) begin
            if (idx == '0) begin
              state_d = ST_LSB;
              idx_d   = IDX_ONE;
            end else begin
              idx_d = idx - IDX_ONE;
            end
          end
        end
        ST_LSB: begin
          if (dclk_fall) begin
            if (idx == IDX_TOP) begin
              state_d = ST_DONE;
            end else begin
              idx_d = idx + IDX_ONE;
            end
          end
        end
        default: begin
          state_d = state;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      half_q <= 1'b0;
    end else if (upd_en) begin
      state  <= state_d;
      idx    <= idx_d;
      half_q <= half_d;
    end
  end

endmodule

// File: rtl/adc_seq_bitsel.sv
module adc_seq_bitsel
  import adc_seq_pkg::*;
#(
  parameter  int W  = 12,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  din,
  input  seq_state_e    state,
  input  logic [IW-1:0] idx,
  output logic          sdo,
  output logic          sdo_en,
  output logic          pwr_dn
);

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic [W-1:0] pick;

  assign word_d = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= word_d;
    end
  end

  // One-hot decode of the bit position, then an OR reduction.
  for (genvar b = 0; b < W; b++) begin : g_pick
    assign pick[b] = word_q[b] & (idx == IW'(b));
  end

  always_comb begin
    sdo_en = (state == ST_NULL) || (state == ST_MSB) || (state == ST_LSB);
    sdo    = (state == ST_NULL) ? 1'b0 : (|pick);
    pwr_dn = (state == ST_IDLE) || (state == ST_LSB) || (state == ST_DONE);
  end

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter  int W      = 12,
  parameter  int STAGES = 2,
  localparam int IW     = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         dclk,
  input  logic [W-1:0] result,
  output logic         sdo,
  output logic         sdo_en,
  output logic         pwr_dn
);

  logic          rst_n_int;
  logic          cs_fall;
  logic          dclk_fall;
  logic          load;
  seq_state_e    state;
  logic [IW-1:0] idx;

  adc_seq_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  adc_seq_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cs_n      (cs_n),
    .dclk      (dclk),
    .cs_fall   (cs_fall),
    .dclk_fall (dclk_fall)
  );

  adc_seq_fsm #(.W(W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cs_n      (cs_n),
    .cs_fall   (cs_fall),
    .dclk_fall (dclk_fall),
    .state     (state),
    .idx       (idx),
    .load      (load)
  );

  adc_seq_bitsel #(.W(W)) u_bits (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load   (load),
    .din    (result),
    .state  (state),
    .idx    (idx),
    .sdo    (sdo),
    .sdo_en (sdo_en),
    .pwr_dn (pwr_dn)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic dclk,
  input logic sdo,
  input logic sdo_en,
  input logic pwr_dn
);

  // R8: select high forces release and power-down in the next cycle.
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!sdo_en && pwr_dn));

  // R2: a select fall opens a frame with the line released and power on.
  p_frame_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && !cs_n) |=> (!sdo_en && !pwr_dn));

  // R4: the first driven bit of a frame is the low lead-in bit.
  p_lead_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> !sdo);

  // R9: power stays on only while select was low.
  p_power_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn |-> !$past(cs_n));

  // R10: without a data-clock fall or select change, the line holds.
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!($past(dclk) && !dclk) && !cs_n && !$past(cs_n))
      |=> ($stable(sdo_en) && (!sdo_en || $stable(sdo))));

endmodule

bind adc_serial_seq adc_seq_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n),
  .dclk   (dclk),
  .sdo    (sdo),
  .sdo_en (sdo_en),
  .pwr_dn (pwr_dn)
);

// File: tb/test_adc_serial_seq.sv
`timescale 1ns/1ps
module test_adc_serial_seq;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        dclk;
  logic [11:0] result;
  logic        sdo;
  logic        sdo_en;
  logic        pwr_dn;

  int n_cmp;
  int n_bad;
  int seed;

  adc_serial_seq i_adc_serial_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .dclk   (dclk),
    .result (result),
    .sdo    (sdo),
    .sdo_en (sdo_en),
    .pwr_dn (pwr_dn)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected behaviour after falling edge k of a frame (k=0: just started).
  function automatic bit exp_en(int k);
    return (k >= 2) && (k <= 25);
  endfunction

  function automatic bit exp_pd(int k);
    return k >= 15;
  endfunction

  function automatic bit exp_bit(int k, logic [11:0] w);
    if (k <= 2) return 1'b0;
    if (k <= 14) return w[14-k];
    return w[k-14];
  endfunction

  function automatic string pos_tag(int k);
    if (k <= 1) return "R3";
    if (k == 2) return "R4";
    if (k <= 14) return "R5";
    if (k <= 25) return "R6";
    return "R7";
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_pos(string tag, string vtag, int k, logic [11:0] w);
    cmp(tag, "sdo_en", sdo_en, exp_en(k));
    if (exp_en(k)) cmp((vtag != "") ? vtag : tag, "sdo", sdo, exp_bit(k, w));
    cmp("R9", "pwr_dn", pwr_dn, exp_pd(k));
  endtask

  task automatic check_idle(string tag);
    cmp(tag, "sdo_en", sdo_en, 0);
    cmp(tag, "pwr_dn", pwr_dn, 1);
  endtask

  // One frame of nf data-clock falls; abort_k>0 raises select after that fall.
  task automatic run_frame(logic [11:0] w, int nf, int abort_k, string vtag);
    int hi;
    int lo;
    @(negedge clk);
    result = w;
    cs_n   = 1'b0;
    tick();
    cmp("R2", "sdo_en", sdo_en, 0);
    cmp("R2", "pwr_dn", pwr_dn, 0);
    @(negedge clk);
    result = ~w;  // R2: captured word must be used, not the live input
    for (int k = 1; k <= nf; k++) begin
      hi = 1 + $urandom_range(2);
      lo = $urandom_range(2);
      @(negedge clk);
      dclk = 1'b1;
      for (int i = 0; i < hi; i++) begin
        tick();
        check_pos("R10", vtag, k - 1, w);
      end
      @(negedge clk);
      dclk = 1'b0;
      tick();
      check_pos(pos_tag(k), vtag, k, w);
      for (int i = 0; i < lo; i++) begin
        tick();
        check_pos("R10", vtag, k, w);
      end
      if (k == abort_k) break;
    end
    @(negedge clk);
    cs_n = 1'b1;
    tick();
    check_idle("R8");
    // Clocks with select high do nothing.
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      dclk = 1'b1;
      tick();
      @(negedge clk);
      dclk = 1'b0;
      tick();
      check_idle("R8");
    end
  endtask

  initial begin
    n_cmp  = 0;
    n_bad  = 0;
    seed   = 7741;
    void'($urandom(seed));
    rst_n  = 1'b0;
    cs_n   = 1'b1;
    dclk   = 1'b0;
    result = 12'h000;
    repeat (3) tick();
    check_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) tick();
    check_idle("R1");

    // R11: extreme two's complement codes, plus R7 run-on past edge 26.
    run_frame(12'h7FF, 28, 0, "R11");
    run_frame(12'h800, 28, 0, "R11");
    run_frame(12'hFFF, 26, 0, "R11");
    run_frame(12'h000, 30, 0, "R11");
    run_frame(12'hA5C, 26, 0, "");
    // R8: directed aborts in the window, lead-in, MSB half and replay.
    run_frame(12'h3C6, 30, 1, "");
    run_frame(12'h3C6, 30, 2, "");
    run_frame(12'h9B1, 30, 9, "");
    run_frame(12'h9B1, 30, 18, "");

    for (int f = 0; f < 40; f++) begin
      logic [11:0] w;
      int nf;
      int ab;
      w  = 12'($urandom());
      nf = 26 + $urandom_range(4);
      ab = ($urandom_range(3) == 0) ? 1 + $urandom_range(24) : 0;
      run_frame(w, nf, ab, "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule